// File: doc/BRIEF.md
# Correlated double sampling strobe generator

This block generates the two timing strobes that a correlated double sampling front end needs. The reset-level strobe marks the sampling of the sensor's reset voltage. The video-level strobe marks the sampling of the signal voltage. Both strobes come from one fast clock that runs at 2·SUB ticks per pixel. A phase counter splits every pixel into two halves of SUB ticks. The reset strobe occupies the first half and the video strobe the second. The block also produces a pixel clock that is low in the first half and high in the second. A skew input rotates the whole pattern, so both edges of both strobes move by the same number of ticks.

Each strobe's real sampling instant is its falling edge. An external active-low override input can end a strobe early, and each strobe has its own override input. The reset override is timed from the falling edge of the pixel clock, which is the start of the pixel. The video override is timed from the rising edge of the pixel clock, which is the middle of the pixel. An override edge is honoured only when all of the following hold:
- it arrives at least MIN_GAP ticks after its reference edge;
- it arrives early enough that it really shortens the pulse;
- its configuration bit is set.

The override never moves the rising edge. A per-strobe flag reports which strobe was cut short in the current pixel.

Top module: `cds_strobe_gen`

## Requirements
- R1: While `rst_n` is low, `strb_rst`, `strb_vid`, `pix_clk` and `ovr_used` are all 0. The first pixel position (position 0) is presented in the cycle after the first rising clock edge with `rst_n` high.
- R2: With `skew` = 0, the pixel position counts 0 to 2·SUB−1 and then wraps. `strb_rst` is high at positions 0 to SUB−1, and `pix_clk` is low there. The reset strobe rises together with the falling edge of `pix_clk`.
- R3: With `skew` = 0, `strb_vid` is high and `pix_clk` is high at positions SUB to 2·SUB−1.
- R4: `strb_rst` and `strb_vid` are never high in the same cycle.
- R5: A value k on `skew` shifts `strb_rst`, `strb_vid` and `pix_clk` together by k positions. The output pattern at counter position p equals the unskewed pattern at position (p+k) mod 2·SUB.
- R6: Suppose `ovr_rst_n` is seen high in one cycle and low in the next, at reset-relative position r, with MIN_GAP ≤ r ≤ SUB−2 and `ovr_en[0]` = 1. Then `strb_rst` falls in the following cycle and stays low for the rest of the window.
- R7: The same applies to `ovr_vid_n` at video-relative position r, meaning pixel position SUB+r, gated by `ovr_en[1]`. It shortens `strb_vid`.
- R8: An override falling edge has no effect on either strobe or flag in these cases:
  - it arrives before MIN_GAP ticks after its reference edge;
  - it arrives at relative position SUB−1 or later;
  - it arrives outside its own strobe's window.
- R9: When an override's bit in `ovr_en` is 0 (bit 0 reset, bit 1 video), that override input has no effect on the outputs.
- R10: `ovr_used[0]` (reset) and `ovr_used[1]` (video) go to 1 in the cycle after an accepted override edge. Each stays at 1 until the cycle just before its own strobe's next window begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, 2·SUB ticks per pixel |
| rst_n | input | 1 | Asynchronous active-low reset |
| skew | input | TW | Phase rotation of the pixel pattern in ticks (TW = clog2(2·SUB)) |
| ovr_en | input | 2 | Override enables: bit 0 reset strobe, bit 1 video strobe |
| ovr_rst_n | input | 1 | Active-low reset-strobe override; its falling edge ends the strobe |
| ovr_vid_n | input | 1 | Active-low video-strobe override; its falling edge ends the strobe |
| strb_rst | output | 1 | Reset-level sampling strobe |
| strb_vid | output | 1 | Video-level sampling strobe |
| pix_clk | output | 1 | Pixel clock derived from the phase counter |
| ovr_used | output | 2 | Per-strobe flag showing the strobe was cut short this pixel |

## Verification
The bench drives override edges at each edge of the acceptance window and also one tick outside it on both sides. A design whose window is off by one would either clip a pulse that should be full length or miss a legal cut. Edges at position 0 and position SUB test the reference-edge guard: a design that ignores that guard would shorten the strobe at once. The bench drives crossed enable patterns to catch a swapped or unmasked override, in which the wrong strobe would shrink. It also applies a nonzero skew, which exposes a design that rotates only one of the three waveforms. A mid-run reset exposes a design that resumes counting from a stale position.

// File: rtl/cds_pkg.sv
package cds_pkg;

   typedef enum int unsigned {
      LANE_RST = 0,
      LANE_VID = 1
   } lane_e;

   localparam int unsigned NUM_LANES = 2;

endpackage

// File: rtl/cds_phase_counter.sv
module cds_phase_counter #(
   parameter int unsigned PIX = 8,
   parameter int unsigned TW  = $clog2(PIX)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] skew,
   output logic          live,
   output logic [TW-1:0] pos
);

   localparam logic [TW-1:0] LAST = TW'(PIX - 1);
   localparam logic [TW:0]   PIXW = (TW+1)'(PIX);

   logic [TW-1:0] tick;
   logic [TW:0]   sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live <= 1'b0;
         tick <= '0;
      end else begin
         live <= 1'b1;
         if (live) begin
            tick <= (tick == LAST) ? '0 : tick + 1'b1;
         end
      end
   end

   always_comb begin
      sum = {1'b0, tick} + {1'b0, skew};
      if (sum >= PIXW) begin
         sum = sum - PIXW;
      end
      pos = sum[TW-1:0];
   end

   // R2: the counter wraps after the last position of a pixel
   assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (live && tick == LAST) |=> (tick == '0));

   // R1: the counter holds at position zero until running
   assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!live) |=> (tick == '0));

endmodule

// File: rtl/cds_strobe_lane.sv
module cds_strobe_lane #(
   parameter int unsigned SUB     = 4,
   parameter int unsigned START   = 0,
   parameter int unsigned MIN_GAP = 1,
   parameter int unsigned TW      = $clog2(2*SUB)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          live,
   input  logic [TW-1:0] pos,
   input  logic          en,
   input  logic          ovr_n,
   output logic          strb,
   output logic          used
);

   localparam int unsigned   PIX    = 2 * SUB;
   localparam logic [TW:0]   WBEG   = (TW+1)'(START);
   localparam logic [TW:0]   WEND   = (TW+1)'(START + SUB);
   localparam logic [TW-1:0] PRE    = TW'((START + PIX - 1) % PIX);
   localparam logic [TW-1:0] GAP_LO = TW'(MIN_GAP);
   localparam logic [TW-1:0] GAP_HI = TW'(SUB - 2);

   logic          ovr_q;
   logic          cut;
   logic          in_win;
   logic [TW-1:0] rel;
   logic          fall;
   logic          accept;

   always_comb begin
      in_win = ({1'b0, pos} >= WBEG) && ({1'b0, pos} < WEND);
      rel    = pos - TW'(START);
      fall   = ovr_q && !ovr_n && en;
      accept = live && fall && in_win && (rel >= GAP_LO) && (rel <= GAP_HI);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q <= 1'b1;
         cut   <= 1'b0;
      end else begin
         ovr_q <= ovr_n;
         if (pos == PRE) begin
            cut <= 1'b0;
         end else if (accept) begin
            cut <= 1'b1;
         end
      end
   end

   assign strb = live && in_win && !cut;
   assign used = cut;

   // R9: a masked override never cuts the strobe
   assert_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !cut) |=> !cut);

   // R8: an edge too close to the reference edge is ignored
   assert_early_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && rel < GAP_LO && !cut) |=> !cut);

   // R8: an edge outside the window is ignored
   assert_outside_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_win && !cut) |=> !cut);

   // R6 / R7: an accepted cut ends the strobe in the next cycle
   assert_cut_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && pos != PRE) |=> !strb);

   // R10: the flag clears just before the window opens again
   assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pos == PRE) |=> !used);

endmodule

// File: rtl/cds_strobe_gen.sv
module cds_strobe_gen #(
   parameter int unsigned SUB     = 4,
   parameter int unsigned MIN_GAP = 1,
   parameter int unsigned TW      = $clog2(2*SUB)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] skew,
   input  logic [1:0]    ovr_en,
   input  logic          ovr_rst_n,
   input  logic          ovr_vid_n,
   output logic          strb_rst,
   output logic          strb_vid,
   output logic          pix_clk,
   output logic [1:0]    ovr_used
);

   import cds_pkg::*;

   localparam int unsigned PIX  = 2 * SUB;
   localparam logic [TW:0] HALF = (TW+1)'(SUB);

   if (SUB < MIN_GAP + 2) begin : g_bad_gap
      $error("SUB must leave room for a cut after MIN_GAP");
   end
   if (MIN_GAP < 1) begin : g_bad_min
      $error("MIN_GAP must be at least one tick");
   end
   if (TW < $clog2(PIX)) begin : g_bad_tw
      $error("TW too narrow for the pixel position");
   end

   logic                 live;
   logic [TW-1:0]        pos;
   logic [NUM_LANES-1:0] ovr_in;
   logic [NUM_LANES-1:0] strb;
   logic [NUM_LANES-1:0] used;

   assign ovr_in[LANE_RST] = ovr_rst_n;
   assign ovr_in[LANE_VID] = ovr_vid_n;

   cds_phase_counter #(.PIX(PIX), .TW(TW)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .skew  (skew),
      .live  (live),
      .pos   (pos)
   );

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      cds_strobe_lane #(
         .SUB     (SUB),
         .START   (i * SUB),
         .MIN_GAP (MIN_GAP),
         .TW      (TW)
      ) u_lane (
         .clk   (clk),
         .rst_n (rst_n),
         .live  (live),
         .pos   (pos),
         .en    (ovr_en[i]),
         .ovr_n (ovr_in[i]),
         .strb  (strb[i]),
         .used  (used[i])
      );
   end

   assign strb_rst = strb[LANE_RST];
   assign strb_vid = strb[LANE_VID];
   assign pix_clk  = live && ({1'b0, pos} >= HALF);
   assign ovr_used = used;

   // R4: strobes never overlap
   assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(strb_rst && strb_vid));

   // R2: the reset strobe rises with the falling edge of the pixel clock
   assert_rst_rise_on_pix_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(strb_rst) && $stable(skew) && $past(live)) |-> $fell(pix_clk));

   // R3: the video strobe only runs while the pixel clock is high
   assert_vid_in_high_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
      strb_vid |-> pix_clk);

   // R1: nothing is driven before the counter runs
   assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !live |-> (!strb_rst && !strb_vid && !pix_clk));

endmodule

// File: tb/cds_strobe_gen_test.sv
module cds_strobe_gen_test;

   localparam int CLK_PERIOD = 10;
   localparam int SUB = 4;
   localparam int TW  = 3;
   localparam int NV  = 13;
   localparam logic [3:0] NONE = 4'd15;

   // fields: en[27:26] rt[25:22] vt[21:18] exp_rst[17:10] exp_vid[9:2] exp_used[1:0]
   localparam logic [27:0] VEC [NV] = '{
      {2'b11, NONE,  NONE,  8'h0F, 8'hF0, 2'b00},  // R2 R3 plain
      {2'b11, 4'd1,  NONE,  8'h03, 8'hF0, 2'b01},  // R6 cut at gap
      {2'b11, 4'd2,  NONE,  8'h07, 8'hF0, 2'b01},  // R6 cut at last legal
      {2'b11, 4'd0,  NONE,  8'h0F, 8'hF0, 2'b00},  // R8 at reference edge
      {2'b11, 4'd3,  NONE,  8'h0F, 8'hF0, 2'b00},  // R8 too late
      {2'b11, NONE,  4'd5,  8'h0F, 8'h30, 2'b10},  // R7 cut at gap
      {2'b11, NONE,  4'd6,  8'h0F, 8'h70, 2'b10},  // R7 cut at last legal
      {2'b11, NONE,  4'd4,  8'h0F, 8'hF0, 2'b00},  // R8 at reference edge
      {2'b11, NONE,  4'd2,  8'h0F, 8'hF0, 2'b00},  // R8 outside window
      {2'b00, 4'd1,  4'd5,  8'h0F, 8'hF0, 2'b00},  // R9 both masked
      {2'b01, 4'd1,  4'd5,  8'h03, 8'hF0, 2'b01},  // R9 video masked
      {2'b10, 4'd1,  4'd5,  8'h0F, 8'h30, 2'b10},  // R9 reset masked
      {2'b11, 4'd2,  4'd6,  8'h07, 8'h70, 2'b11}   // R10 both cut
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [TW-1:0] skew = '0;
   logic [1:0]    ovr_en = 2'b00;
   logic          ovr_rst_n = 1'b1;
   logic          ovr_vid_n = 1'b1;
   logic          strb_rst, strb_vid, pix_clk;
   logic [1:0]    ovr_used;

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;

   cds_strobe_gen #(.SUB(SUB), .MIN_GAP(1), .TW(TW)) uut (
      .clk(clk), .rst_n(rst_n), .skew(skew), .ovr_en(ovr_en),
      .ovr_rst_n(ovr_rst_n), .ovr_vid_n(ovr_vid_n),
      .strb_rst(strb_rst), .strb_vid(strb_vid), .pix_clk(pix_clk),
      .ovr_used(ovr_used)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // starts and ends at the negedge of position 0
   task automatic run_pixel(input logic [1:0] en, input logic [3:0] rt, input logic [3:0] vt,
                            output logic [7:0] r, output logic [7:0] v,
                            output logic [7:0] p, output logic [1:0] u);
      ovr_en = en;
      r = '0; v = '0; p = '0; u = '0;
      for (int t = 0; t < 2*SUB; t++) begin
         r[t] = strb_rst;
         v[t] = strb_vid;
         p[t] = pix_clk;
         if (t == 2*SUB-1) u = ovr_used;
         if (4'(t) == rt) ovr_rst_n = 1'b0;
         if (4'(t) == vt) ovr_vid_n = 1'b0;
         if (t == 2*SUB-1) begin
            ovr_rst_n = 1'b1;
            ovr_vid_n = 1'b1;
         end
         @(negedge clk);
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 5000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=5000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
         end
      end
   end

   initial begin
      logic [7:0] r, v, p;
      logic [1:0] u;
      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 reset outputs", {4'b0, strb_rst, strb_vid, pix_clk, 1'b0}, 8'h00);
      chk("R1 reset flags", {6'b0, ovr_used}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         run_pixel(VEC[i][27:26], VEC[i][25:22], VEC[i][21:18], r, v, p, u);
         chk($sformatf("R2/R6/R8/R9 reset strobe vec%0d", i), r, VEC[i][17:10]);
         chk($sformatf("R3/R7/R8/R9 video strobe vec%0d", i), v, VEC[i][9:2]);
         chk($sformatf("R2 R3 pixel clock vec%0d", i), p, 8'hF0);
         chk($sformatf("R10 used flags vec%0d", i), {6'b0, u}, {6'b0, VEC[i][1:0]});
         chk($sformatf("R4 overlap vec%0d", i), r & v, 8'h00);
      end

      // R5 skew rotates everything together
      skew = 3'd2;
      run_pixel(2'b00, NONE, NONE, r, v, p, u);
      run_pixel(2'b00, NONE, NONE, r, v, p, u);
      chk("R5 skewed reset strobe", r, 8'hC3);
      chk("R5 skewed video strobe", v, 8'h3C);
      chk("R5 skewed pixel clock", p, 8'h3C);
      chk("R4 skewed overlap", r & v, 8'h00);
      skew = '0;
      run_pixel(2'b00, NONE, NONE, r, v, p, u);

      // R1 reset in mid run, restart from position zero
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 mid-run reset outputs", {5'b0, strb_rst, strb_vid, pix_clk}, 8'h00);
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      run_pixel(2'b11, NONE, NONE, r, v, p, u);
      chk("R1 R2 restart reset strobe", r, 8'h0F);
      chk("R1 R3 restart video strobe", v, 8'hF0);
      chk("R1 restart pixel clock", p, 8'hF0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule